// File: doc/BRIEF.md
# CPU Run, Single-Step and Slow-Step Controller

This block decides whether an 8-bit bus processor may finish its current bus cycle. It drives the bus ready line and can hold a cycle at its start, so the processor stalls with address, data and status frozen on the bus. The operator can let the machine run freely, stop it, and step it. A step releases either one opcode-fetch (M1) cycle or any single bus cycle. An automatic stepper releases held cycles at a programmable rate.

A breakpoint unit can stop a running machine by raising a request. The request takes effect on the cycle it is raised with. An arm switch decides whether such requests are honoured.

The switches reach the block already debounced. The `cyc_start` strobe is high for one clock at the first clock of every bus cycle, with `m1_cyc` valid alongside it. The slow stepper counts a fixed prescaler (`PRE_DIV` clocks, typically one millisecond) times the rate value. A rate of 1 to 1000 therefore gives roughly 1000 down to 1 steps per second.

Top module: `cpu_step_ctrl`

## Requirements
- R1: After synchronous reset `ready` is 1 and `stopped` is 1.
- R2: While `run_sw`=1 and no breakpoint is latched, `ready` never goes low, whatever cycles start.
- R3: While stopped with `step_any_sw`=1, a `cyc_start` pulse drives `ready` low from the next clock. It stays low until a release occurs.
- R4: While stopped with `step_any_sw`=0 (M1-only stepping), a cycle starting with `m1_cyc`=0 passes with `ready` high, and a cycle starting with `m1_cyc`=1 is held.
- R5: A rising edge of `step_btn` while a cycle is held raises `ready` on the next clock. Keeping the button high releases nothing more. A press while no cycle is held has no effect, so the next qualifying cycle is still held.
- R6: Setting `run_sw`=1 while a cycle is held raises `ready` on the next clock.
- R7: With `brk_arm`=1, `brk_hit`=1 while running latches a stop on the same clock. A cycle starting together with the request is held, and `stopped` rises one clock later. The latch stays set until `run_sw` is seen at 0.
- R8: With `brk_arm`=0, `brk_hit` has no effect: `ready` and `stopped` behave as if it were 0.
- R9: With `slow_sw`=1, step events come only from an internal divider that is cleared whenever `slow_sw` is 0. The button is ignored. Releases of promptly re-held cycles are spaced exactly `PRE_DIV` × `step_rate` clocks apart.
- R10: A `step_rate` of 0 behaves as 1.
- R11: `stopped` is a registered flag: one clock after the inputs it is 0 when running without a latched break, otherwise 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-clock pulse at the start of each bus cycle |
| m1_cyc | input | 1 | 1 when the starting cycle is an opcode fetch |
| run_sw | input | 1 | 1 = run, 0 = stop |
| step_any_sw | input | 1 | 1 = step any cycle, 0 = step M1 cycles only |
| step_btn | input | 1 | Step request level, acted on at its rising edge |
| slow_sw | input | 1 | 1 = automatic slow stepping |
| step_rate | input | RATE_W | Slow-step terminal count in prescaler ticks |
| brk_hit | input | 1 | Breakpoint match request |
| brk_arm | input | 1 | 1 = breakpoint requests are honoured |
| ready | output | 1 | Bus ready, 0 holds the current cycle |
| stopped | output | 1 | 1 = controller is in stop mode |

## Verification
The bench aims at several timing-sensitive cases:
- A break raised on the very clock a cycle starts. A design that latched it one clock late would let that cycle escape.
- A step button kept high across several cycles. A level-sensitive design would keep releasing cycles.
- Non-M1 cycles in M1-only mode. A design that held them would stall the machine.
- The slow stepper at rate zero and at other small rates. Off-by-one errors in the divider show up as a wrong release spacing.
- A button press with nothing held. A design that stored it as a credit would let the next cycle through unheld.

// File: rtl/cpu_step_pkg.sv
package cpu_step_pkg;

  // Switch bundle gathered at the top for internal routing.
  typedef struct packed {
    logic run;
    logic any_cyc;
    logic slow;
    logic arm;
  } panel_sw_t;

  // State of the bus cycle currently presented by the processor.
  typedef enum logic {
    CYC_FREE = 1'b0,
    CYC_HELD = 1'b1
  } cyc_state_e;

  // Counter width for a modulus, at least one bit.
  function automatic int unsigned cnt_w(input int unsigned modulus);
    return (modulus <= 1) ? 1 : $clog2(modulus);
  endfunction

endpackage

// File: rtl/step_edge_det.sv
module step_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  // R5
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/step_rate_div.sv
module step_rate_div #(
  parameter int unsigned PRE_DIV = 100000,
  parameter int unsigned RATE_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);

  logic              base_tick;
  logic [RATE_W-1:0] rate_eff;
  logic [RATE_W-1:0] rate_last;
  logic [RATE_W-1:0] rate_cnt_q;
  logic              at_last;

  generate
    if (PRE_DIV <= 1) begin : g_nopre
      assign base_tick = en_i;
    end else begin : g_pre
      localparam int unsigned PW = cpu_step_pkg::cnt_w(PRE_DIV);
      localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk) begin
        if (rst || !en_i)          pre_q <= '0;
        else if (pre_q == PRE_LAST) pre_q <= '0;
        else                       pre_q <= pre_q + PW'(1);
      end

      assign base_tick = en_i && (pre_q == PRE_LAST);

      // R9
      pre_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (pre_q == '0));
    end
  endgenerate

  // R10: zero rate is treated as one prescaler tick per step
  assign rate_eff  = (rate_i == '0) ? RATE_W'(1) : rate_i;
  assign rate_last = rate_eff - RATE_W'(1);
  assign at_last   = (rate_cnt_q >= rate_last);

  always_ff @(posedge clk) begin
    if (rst || !en_i)  rate_cnt_q <= '0;
    else if (base_tick) begin
      if (at_last) rate_cnt_q <= '0;
      else         rate_cnt_q <= rate_cnt_q + RATE_W'(1);
    end
  end

  assign tick_o = base_tick && at_last;

  // R9
  rate_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (rate_cnt_q == '0));

  // R9
  rate_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (rate_cnt_q == '0) && !tick_o);

endmodule

// File: rtl/brk_stop_latch.sv
module brk_stop_latch (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic arm_i,
  input  logic req_i,
  output logic run_now_o
);

  logic latch_q;
  logic hit;
  logic latch_d;

  assign hit       = arm_i & req_i;
  assign latch_d   = run_i & (latch_q | hit);
  assign run_now_o = run_i & ~(latch_q | hit);

  always_ff @(posedge clk) begin
    if (rst) latch_q <= 1'b0;
    else     latch_q <= latch_d;
  end

  // R7
  brk_set_chk: assert property (@(posedge clk) disable iff (rst)
    (run_i && arm_i && req_i) |=> latch_q);

  // R7
  brk_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_q && run_i) |=> latch_q);

  // R8
  brk_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    (!arm_i && !latch_q) |=> !latch_q);

endmodule

// File: rtl/cycle_hold_fsm.sv
module cycle_hold_fsm
  import cpu_step_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cyc_start_i,
  input  logic m1_i,
  input  logic any_i,
  input  logic run_now_i,
  input  logic step_i,
  output logic ready_o,
  output logic stopped_o
);

  cyc_state_e st_q, st_d;
  logic       qualify;

  assign qualify = any_i | m1_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      CYC_FREE: if (cyc_start_i && !run_now_i && qualify) st_d = CYC_HELD;
      CYC_HELD: if (run_now_i || step_i)                  st_d = CYC_FREE;
      default:  st_d = CYC_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= CYC_FREE;
      ready_o   <= 1'b1;
      stopped_o <= 1'b1;
    end else begin
      st_q      <= st_d;
      ready_o   <= (st_d == CYC_FREE);
      stopped_o <= ~run_now_i;
    end
  end

  // R3
  hold_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ready_o) |-> ($past(cyc_start_i) && !$past(run_now_i)));

  // R4
  m1_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_o && cyc_start_i && !any_i && !m1_i) |=> ready_o);

  // R5
  step_rel_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready_o && step_i) |=> ready_o);

  // R6
  run_rel_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready_o && run_now_i) |=> ready_o);

  // R2
  run_nohold_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_o && run_now_i) |=> ready_o);

  // R11
  stat_chk: assert property (@(posedge clk) disable iff (rst)
    run_now_i |=> !stopped_o);

endmodule

// File: rtl/cpu_step_ctrl.sv
module cpu_step_ctrl
  import cpu_step_pkg::*;
#(
  parameter int unsigned RATE_W  = 10,
  parameter int unsigned PRE_DIV = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_start,
  input  logic              m1_cyc,
  input  logic              run_sw,
  input  logic              step_any_sw,
  input  logic              step_btn,
  input  logic              slow_sw,
  input  logic [RATE_W-1:0] step_rate,
  input  logic              brk_hit,
  input  logic              brk_arm,
  output logic              ready,
  output logic              stopped
);

  panel_sw_t sw;
  logic      btn_rise;
  logic      slow_tick;
  logic      step_ev;
  logic      run_now;

  assign sw = '{run: run_sw, any_cyc: step_any_sw, slow: slow_sw, arm: brk_arm};

  step_edge_det u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (step_btn),
    .rise_o (btn_rise)
  );

  step_rate_div #(
    .PRE_DIV (PRE_DIV),
    .RATE_W  (RATE_W)
  ) u_div (
    .clk    (clk),
    .rst    (rst),
    .en_i   (sw.slow),
    .rate_i (step_rate),
    .tick_o (slow_tick)
  );

  brk_stop_latch u_brk (
    .clk       (clk),
    .rst       (rst),
    .run_i     (sw.run),
    .arm_i     (sw.arm),
    .req_i     (brk_hit),
    .run_now_o (run_now)
  );

  // In slow mode the button is ignored; the divider supplies the steps.
  assign step_ev = sw.slow ? slow_tick : btn_rise;

  cycle_hold_fsm u_hold (
    .clk         (clk),
    .rst         (rst),
    .cyc_start_i (cyc_start),
    .m1_i        (m1_cyc),
    .any_i       (sw.any_cyc),
    .run_now_i   (run_now),
    .step_i      (step_ev),
    .ready_o     (ready),
    .stopped_o   (stopped)
  );

  // R1
  rst_ready_chk: assert property (@(posedge clk)
    $past(rst) |-> (ready && stopped));

endmodule

// File: tb/sim_cpu_step_ctrl.sv
`timescale 1ns/1ps
module sim_cpu_step_ctrl;

  localparam int PRE = 5;
  localparam int RW  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 0, m1_cyc = 0, run_sw = 0, step_any_sw = 1;
  logic step_btn = 0, slow_sw = 0, brk_hit = 0, brk_arm = 0;
  logic [RW-1:0] step_rate = '0;
  logic ready, stopped;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic m_ready = 1, m_stopped = 1, m_brk = 0, m_prev = 0;
  int   m_base = 0, m_rcnt = 0;

  always #5 clk = ~clk;

  cpu_step_ctrl #(.RATE_W(RW), .PRE_DIV(PRE)) u0 (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .m1_cyc(m1_cyc),
    .run_sw(run_sw), .step_any_sw(step_any_sw), .step_btn(step_btn),
    .slow_sw(slow_sw), .step_rate(step_rate), .brk_hit(brk_hit),
    .brk_arm(brk_arm), .ready(ready), .stopped(stopped)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int eff_rate(input logic [RW-1:0] r);
    return (r == 0) ? 1 : int'(r);
  endfunction

  // One clock: predict from the requirements, advance, compare at negedge.
  task automatic step_clk(input string tag);
    logic hit, brk_n, run_now, rise, btick, tick, step, hold, hold_n;
    int base_n, rcnt_n;
    hit     = brk_arm & brk_hit;
    brk_n   = run_sw & (m_brk | hit);
    run_now = run_sw & ~(m_brk | hit);
    rise    = step_btn & ~m_prev;
    btick   = slow_sw && (m_base == PRE - 1);
    tick    = btick && (m_rcnt >= eff_rate(step_rate) - 1);
    step    = slow_sw ? tick : rise;
    hold    = ~m_ready;
    if (hold) hold_n = ~(run_now | step);
    else      hold_n = cyc_start & ~run_now & (step_any_sw | m1_cyc);
    base_n = !slow_sw ? 0 : (btick ? 0 : m_base + 1);
    rcnt_n = !slow_sw ? 0 : (btick ? (tick ? 0 : m_rcnt + 1) : m_rcnt);
    @(posedge clk);
    m_ready = ~hold_n; m_stopped = ~run_now; m_brk = brk_n; m_prev = step_btn;
    m_base = base_n; m_rcnt = rcnt_n;
    @(negedge clk);
    chk(tag, "ready", ready, m_ready);
    chk(tag, "stopped", stopped, m_stopped);
  endtask

  task automatic clear_inputs();
    cyc_start = 0; m1_cyc = 0; step_btn = 0; slow_sw = 0;
    brk_hit = 0; brk_arm = 0; step_any_sw = 1; step_rate = '0;
  endtask

  // Free any held cycle by running for two clocks, then stop.
  task automatic settle(input string tag);
    clear_inputs();
    run_sw = 1;
    step_clk(tag); step_clk(tag);
    run_sw = 0;
    step_clk(tag);
  endtask

  task automatic start_cycle(input string tag, input logic is_m1);
    cyc_start = 1; m1_cyc = is_m1;
    step_clk(tag);
    cyc_start = 0; m1_cyc = 0;
  endtask

  // Slow stepping: each release is followed by a new cycle one clock later.
  task automatic slow_run(input string tag, input logic [RW-1:0] rate, input int rises);
    int last = -1, seen = 0, n = 0;
    logic was;
    int exp_gap;
    exp_gap = PRE * eff_rate(rate);
    clear_inputs();
    step_rate = rate; slow_sw = 1; run_sw = 0;
    was = ready;
    while (seen < rises && n < 40 * exp_gap + 40) begin
      cyc_start = m_ready;
      m1_cyc = $urandom % 2;
      step_btn = $urandom % 2;  // button must be ignored in slow mode
      step_clk(tag);
      n++;
      if (ready && !was) begin
        if (last >= 0) begin
          checks++;
          if (n - last != exp_gap) begin
            errors++;
            $display("FAIL %s release spacing: actual %0d expected %0d", tag, n - last, exp_gap);
          end
        end
        last = n; seen++;
      end
      was = ready;
    end
    checks++;
    if (seen < rises) begin
      errors++;
      $display("FAIL %s slow releases: actual %0d expected %0d", tag, seen, rises);
    end
    clear_inputs();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20150620));
    repeat (3) @(negedge clk);
    rst = 0;
    m_ready = 1; m_stopped = 1; m_brk = 0; m_prev = 0; m_base = 0; m_rcnt = 0;
    // R1 reset state
    chk("R1", "ready", ready, 1'b1);
    chk("R1", "stopped", stopped, 1'b1);

    // R2 free run with mixed cycles, R11 status
    run_sw = 1;
    for (int i = 0; i < 12; i++) begin
      cyc_start = $urandom % 2; m1_cyc = $urandom % 2;
      step_clk("R2");
    end
    chk("R11", "stopped in run", stopped, 1'b0);

    // R3 any-cycle hold
    settle("R3");
    start_cycle("R3", 0);
    chk("R3", "held ready", ready, 1'b0);
    repeat (4) step_clk("R3");
    chk("R3", "still held", ready, 1'b0);

    // R5 one press releases one cycle even when kept high
    step_btn = 1; step_clk("R5");
    chk("R5", "released", ready, 1'b1);
    start_cycle("R5", 1);
    repeat (3) step_clk("R5");
    chk("R5", "level does not re-release", ready, 1'b0);
    step_btn = 0; step_clk("R5");
    step_btn = 1; step_clk("R5"); step_btn = 0; step_clk("R5");
    // press with nothing held is dropped
    step_btn = 1; step_clk("R5"); step_btn = 0; step_clk("R5");
    start_cycle("R5", 0);
    chk("R5", "stale press ignored", ready, 1'b0);

    // R6 run releases a held cycle
    run_sw = 1; step_clk("R6");
    chk("R6", "run release", ready, 1'b1);

    // R4 M1-only stepping
    settle("R4");
    step_any_sw = 0;
    start_cycle("R4", 0);
    chk("R4", "non-M1 passes", ready, 1'b1);
    step_clk("R4");
    start_cycle("R4", 1);
    chk("R4", "M1 held", ready, 1'b0);
    step_btn = 1; step_clk("R4"); step_btn = 0;
    start_cycle("R4", 0); start_cycle("R4", 0);
    chk("R4", "memory cycles after step pass", ready, 1'b1);
    start_cycle("R4", 1);
    chk("R4", "next M1 held", ready, 1'b0);

    // R7 armed break on the starting cycle
    settle("R7");
    run_sw = 1; step_clk("R7");
    brk_arm = 1; brk_hit = 1; cyc_start = 1; m1_cyc = 0;
    step_clk("R7");
    brk_hit = 0; cyc_start = 0;
    chk("R7", "break holds cycle", ready, 1'b0);
    chk("R7", "break stops", stopped, 1'b1);
    repeat (3) step_clk("R7");
    chk("R7", "latch persists", ready, 1'b0);
    run_sw = 0; step_clk("R7");
    run_sw = 1; step_clk("R7");
    chk("R7", "rerun after clear", ready, 1'b1);
    chk("R7", "running again", stopped, 1'b0);

    // R8 disarmed break ignored
    brk_arm = 0; brk_hit = 1; cyc_start = 1;
    step_clk("R8");
    cyc_start = 0; step_clk("R8");
    brk_hit = 0;
    chk("R8", "ready unaffected", ready, 1'b1);
    chk("R8", "stopped unaffected", stopped, 1'b0);

    // R9 slow stepping at several rates, R10 zero rate
    settle("R9");
    slow_run("R9", 10'd3, 5);
    settle("R10");
    slow_run("R10", 10'd0, 5);
    for (int k = 0; k < 3; k++) begin
      settle("R9");
      slow_run("R9", RW'(1 + $urandom % 6), 4);
    end

    // Mixed random phase against the model
    settle("R3");
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 20 == 0) run_sw = ~run_sw;
      if ($urandom % 10 == 0) step_any_sw = ~step_any_sw;
      if ($urandom % 25 == 0) brk_arm = ~brk_arm;
      if ($urandom % 60 == 0) begin
        slow_sw = ~slow_sw; step_rate = RW'($urandom % 4);
      end
      step_btn = ($urandom % 3 == 0);
      brk_hit  = ($urandom % 30 == 0);
      cyc_start = m_ready && ($urandom % 3 == 0);
      m1_cyc = $urandom % 2;
      step_clk("R2 R3 R4 R5 R6 R7 R8 R9");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule